// File: doc/BRIEF.md
# BCD Calendar and Time-of-Day Counter

This block holds a full calendar and time of day as packed BCD fields: seconds, minutes, hours in 24-hour form, day of week, date, month, two-digit year and a two-digit century. An upstream prescaler supplies a sub-second enable pulse `sub_tick`. The block counts `PHASES` of these pulses to make one second. At that point it advances the seconds field, and every carry up to the century settles on the same clock edge. Month lengths come from the current month and year, and February gets a 29th day whenever the year is a multiple of four. That rule is exact for the years 2000 to 2099.

Software or a sequencer presets the whole calendar at once through a parallel load port. A load also restarts the sub-second phase, so the first increment after a load comes a full second later. A `stop` input freezes all counting. A two-state machine tracks it:

- `ST_RUN`: counting enabled. It moves to `ST_HALT` on any cycle where `stop` is high.
- `ST_HALT`: frozen. It moves back to `ST_RUN` on the first cycle where `stop` is low.

While the block is in `ST_HALT`, or whenever `stop` is high, neither the fields nor the phase change.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the fields read 00:00:00 for the time, day of week 1, date 01, month 01, year 00 and century 20 (hex 8'h20 on 6 bits), and the sub-second phase is 0.
- R2: Every field is packed BCD, with the tens digit in bits [7:4] and the units digit in bits [3:0]. Seconds advance by one on the `PHASES`-th counted `sub_tick` pulse (default 4). Earlier pulses leave the seconds unchanged, and cycles without `sub_tick` change nothing.
- R3: Seconds wrapping 59→00 increment the minutes. Minutes wrapping 59→00 increment the hours. Hours wrapping 23→00 increment the date. All of these fields change on the same clock edge as the final `sub_tick` of the second.
- R4: The date wraps to 01 after its last value. That last value is 30 for months 04, 06, 09 and 11, is 31 for months 01, 03, 05, 07, 08, 10 and 12, and is 28 or 29 for month 02. The month wraps 12→01 and carries into the year; it steps 09→10 in BCD.
- R5: February has 29 days when the year's value is divisible by four, including year 00, and 28 days otherwise.
- R6: The day of week counts 1 to 7 on a 3-bit port, returns to 1 after 7, and advances exactly when the date advances.
- R7: The year wraps 99→00 and then increments the century. The century is a 6-bit BCD field that wraps 39→00.
- R8: A `load` pulse writes all eight fields on the next clock edge. It takes priority over counting, works while stopped, and clears the sub-second phase.
- R9: While `stop` is high, no field and no phase bit changes. After `stop` goes low, one further cycle stays frozen (`ST_HALT`→`ST_RUN`) before counting resumes.
- R10: A field loaded at or above its current upper limit, such as date 31 in April, wraps to its minimum on its next increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sub_tick | input | 1 | Sub-second enable pulse, PHASES per second |
| stop | input | 1 | Freeze counting while high |
| load | input | 1 | Write all ld_* fields on the next edge |
| ld_sec | input | 8 | Seconds preset, BCD |
| ld_min | input | 8 | Minutes preset, BCD |
| ld_hour | input | 8 | Hours preset, BCD, 24-hour |
| ld_dow | input | 3 | Day-of-week preset, 1..7 |
| ld_date | input | 8 | Date preset, BCD |
| ld_month | input | 8 | Month preset, BCD |
| ld_year | input | 8 | Year preset, BCD |
| ld_century | input | 6 | Century preset, BCD 00..39 |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, BCD |
| dow_o | output | 3 | Day of week |
| date_o | output | 8 | Date, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year, BCD |
| century_o | output | 6 | Century, BCD |

## Verification
The bench presets the calendar just below each boundary and then steps exactly one second. Time-only carries check that a carry stops at the right field. Ends of 30-day and 31-day months separate the month-length table from the plain date wrap. February 28th is tried in years 24, 23, 12, 10 and 00; these cover both parities of the tens digit, which a leap test looking only at the units digit would get wrong. Rollovers at year end with century 20 and century 39 set the century increment apart from its own wrap. Pulses sent while stopped and a load placed in the middle of a second show whether the phase counter is held and whether it is restarted.

// File: rtl/calendar_pkg.sv
`timescale 1ns/1ps
package calendar_pkg;

    typedef logic [7:0] bcd8_t;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } run_state_e;

    localparam int NUM_FIELDS = 8;
    localparam int F_SEC   = 0;
    localparam int F_MIN   = 1;
    localparam int F_HOUR  = 2;
    localparam int F_DATE  = 3;
    localparam int F_MONTH = 4;
    localparam int F_YEAR  = 5;
    localparam int F_CENT  = 6;
    localparam int F_DOW   = 7;

    // Next value of a two-digit BCD number, no wrap handling.
    function automatic bcd8_t bcd_next(input bcd8_t v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // 10*t + u is congruent to 2*t + u modulo 4.
    function automatic logic year_is_leap(input bcd8_t y);
        logic [1:0] m;
        m = y[1:0] + {y[4], 1'b0};
        return (m == 2'd0);
    endfunction

    function automatic bcd8_t field_top(input int idx);
        case (idx)
            F_SEC, F_MIN: return 8'h59;
            F_HOUR:       return 8'h23;
            F_DATE:       return 8'h31;
            F_MONTH:      return 8'h12;
            F_YEAR:       return 8'h99;
            F_CENT:       return 8'h39;
            default:      return 8'h07;
        endcase
    endfunction

    function automatic bcd8_t field_floor(input int idx);
        case (idx)
            F_DATE, F_MONTH, F_DOW: return 8'h01;
            default:                return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/calendar_bcd_field.sv
`timescale 1ns/1ps
module calendar_bcd_field
    import calendar_pkg::*;
#(
    parameter bcd8_t FLOOR = 8'h00,
    parameter bcd8_t RST   = 8'h00
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  bcd8_t ld_val,
    input  logic  inc,
    input  bcd8_t top,
    output bcd8_t q,
    output logic  carry
);

    // At-or-above compare keeps an out-of-range preset from running away.
    always_comb carry = inc && (q >= top);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= RST;
        else if (load)  q <= ld_val;
        else if (inc)   q <= carry ? FLOOR : bcd_next(q);
    end

endmodule

// File: rtl/calendar_month_len.sv
`timescale 1ns/1ps
module calendar_month_len
    import calendar_pkg::*;
(
    input  bcd8_t month,
    input  bcd8_t year,
    output bcd8_t last_date
);

    always_comb begin
        unique case (month)
            8'h02:                     last_date = year_is_leap(year) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
            default:                   last_date = 8'h31;
        endcase
    end

endmodule

// File: rtl/bcd_calendar.sv
`timescale 1ns/1ps
module bcd_calendar
    import calendar_pkg::*;
#(
    parameter int          PHASES        = 4,
    parameter logic [5:0]  RESET_CENTURY = 6'h20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sub_tick,
    input  logic       stop,
    input  logic       load,
    input  logic [7:0] ld_sec,
    input  logic [7:0] ld_min,
    input  logic [7:0] ld_hour,
    input  logic [2:0] ld_dow,
    input  logic [7:0] ld_date,
    input  logic [7:0] ld_month,
    input  logic [7:0] ld_year,
    input  logic [5:0] ld_century,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [2:0] dow_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o,
    output logic [5:0] century_o
);

    localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1;
    localparam logic [PW-1:0] PH_LAST = PW'(PHASES - 1);

    run_state_e    state_q, state_d;
    logic [PW-1:0] phase_q;
    logic          count_en, second_adv;

    bcd8_t                 fld_q     [NUM_FIELDS];
    bcd8_t                 fld_ld    [NUM_FIELDS];
    bcd8_t                 fld_top   [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] fld_inc;
    logic [NUM_FIELDS-1:0] fld_carry;
    bcd8_t                 date_last;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (stop)  state_d = ST_HALT;
            ST_HALT: if (!stop) state_d = ST_RUN;
        endcase
    end

    // Outputs of the state machine: count enable and second strobe
    always_comb begin
        count_en = 1'b0;
        unique case (state_q)
            ST_RUN:  count_en = !stop && !load;
            ST_HALT: count_en = 1'b0;
        endcase
        second_adv = count_en && sub_tick && (phase_q == PH_LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     phase_q <= '0;
        else if (load)                  phase_q <= '0;
        else if (count_en && sub_tick)  phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
    end

    calendar_month_len u_mlen (
        .month     (fld_q[F_MONTH]),
        .year      (fld_q[F_YEAR]),
        .last_date (date_last)
    );

    always_comb begin
        fld_ld[F_SEC]   = ld_sec;
        fld_ld[F_MIN]   = ld_min;
        fld_ld[F_HOUR]  = ld_hour;
        fld_ld[F_DATE]  = ld_date;
        fld_ld[F_MONTH] = ld_month;
        fld_ld[F_YEAR]  = ld_year;
        fld_ld[F_CENT]  = {2'b00, ld_century};
        fld_ld[F_DOW]   = {5'b00000, ld_dow};
    end

    // Carry chain seconds -> century; day of week follows the date.
    always_comb begin
        fld_inc[F_SEC]   = second_adv;
        fld_inc[F_MIN]   = fld_carry[F_SEC];
        fld_inc[F_HOUR]  = fld_carry[F_MIN];
        fld_inc[F_DATE]  = fld_carry[F_HOUR];
        fld_inc[F_MONTH] = fld_carry[F_DATE];
        fld_inc[F_YEAR]  = fld_carry[F_MONTH];
        fld_inc[F_CENT]  = fld_carry[F_YEAR];
        fld_inc[F_DOW]   = fld_carry[F_HOUR];
    end

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        localparam bcd8_t RV = (i == F_CENT) ? {2'b00, RESET_CENTURY} : field_floor(i);

        if (i == F_DATE) begin : g_dyn
            assign fld_top[i] = date_last;
        end else begin : g_fix
            assign fld_top[i] = field_top(i);
        end

        calendar_bcd_field #(
            .FLOOR (field_floor(i)),
            .RST   (RV)
        ) u_fld (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (load),
            .ld_val (fld_ld[i]),
            .inc    (fld_inc[i]),
            .top    (fld_top[i]),
            .q      (fld_q[i]),
            .carry  (fld_carry[i])
        );
    end

    assign sec_o     = fld_q[F_SEC];
    assign min_o     = fld_q[F_MIN];
    assign hour_o    = fld_q[F_HOUR];
    assign date_o    = fld_q[F_DATE];
    assign month_o   = fld_q[F_MONTH];
    assign year_o    = fld_q[F_YEAR];
    assign century_o = fld_q[F_CENT][5:0];
    assign dow_o     = fld_q[F_DOW][2:0];

endmodule

// File: rtl/bcd_calendar_checker.sv
`timescale 1ns/1ps
module bcd_calendar_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sub_tick,
    input logic       stop,
    input logic       load,
    input logic [7:0] ld_sec,
    input logic [7:0] ld_date,
    input logic [5:0] ld_century,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hour_o,
    input logic [2:0] dow_o,
    input logic [7:0] date_o,
    input logic [7:0] month_o,
    input logic [7:0] year_o,
    input logic [5:0] century_o
);

    // R2: seconds stay valid BCD within 00..59
    assert_sec_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_o <= 8'h59) && (sec_o[3:0] <= 4'd9));

    // R2: no sub-second pulse and no load means nothing moves
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sub_tick && !load) |=> ($stable(sec_o) && $stable(min_o) && $stable(date_o)));

    // R6: day of week stays in 1..7
    assert_dow_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dow_o >= 3'd1) && (dow_o <= 3'd7));

    // R7: century only moves on the year 99 -> 00 wrap
    assert_century_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(century_o) || ($past(year_o) == 8'h99 && year_o == 8'h00)));

    // R8: load lands on the next edge
    assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sec_o == $past(ld_sec) && date_o == $past(ld_date) && century_o == $past(ld_century)));

    // R9: stop freezes every field
    assert_stop_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !load) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) && $stable(dow_o)
                             && $stable(date_o) && $stable(month_o) && $stable(year_o)
                             && $stable(century_o)));

endmodule

bind bcd_calendar bcd_calendar_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sub_tick   (sub_tick),
    .stop       (stop),
    .load       (load),
    .ld_sec     (ld_sec),
    .ld_date    (ld_date),
    .ld_century (ld_century),
    .sec_o      (sec_o),
    .min_o      (min_o),
    .hour_o     (hour_o),
    .dow_o      (dow_o),
    .date_o     (date_o),
    .month_o    (month_o),
    .year_o     (year_o),
    .century_o  (century_o)
);

// File: tb/bcd_calendar_bench.sv
`timescale 1ns/1ps
module bcd_calendar_bench;

    localparam int PHASES = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sub_tick = 1'b0;
    logic       stop = 1'b0;
    logic       load = 1'b0;
    logic [7:0] ld_sec = '0, ld_min = '0, ld_hour = '0, ld_date = '0, ld_month = '0, ld_year = '0;
    logic [2:0] ld_dow = '0;
    logic [5:0] ld_century = '0;
    logic [7:0] sec_o, min_o, hour_o, date_o, month_o, year_o;
    logic [2:0] dow_o;
    logic [5:0] century_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    bcd_calendar #(.PHASES(PHASES), .RESET_CENTURY(6'h20)) u_bcd_calendar (
        .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .stop(stop), .load(load),
        .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour), .ld_dow(ld_dow),
        .ld_date(ld_date), .ld_month(ld_month), .ld_year(ld_year), .ld_century(ld_century),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
        .date_o(date_o), .month_o(month_o), .year_o(year_o), .century_o(century_o)
    );

    task automatic cmp(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic check_all(input string req,
                             input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                             input logic [2:0] w, input logic [7:0] d, input logic [7:0] mo,
                             input logic [7:0] y, input logic [5:0] c);
        cmp(req, "sec",     sec_o,            s);
        cmp(req, "min",     min_o,            m);
        cmp(req, "hour",    hour_o,           h);
        cmp(req, "dow",     {5'b0, dow_o},    {5'b0, w});
        cmp(req, "date",    date_o,           d);
        cmp(req, "month",   month_o,          mo);
        cmp(req, "year",    year_o,           y);
        cmp(req, "century", {2'b0, century_o}, {2'b0, c});
    endtask

    task automatic do_load(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                           input logic [2:0] w, input logic [7:0] d, input logic [7:0] mo,
                           input logic [7:0] y, input logic [5:0] c);
        ld_sec = s; ld_min = m; ld_hour = h; ld_dow = w;
        ld_date = d; ld_month = mo; ld_year = y; ld_century = c;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            sub_tick = 1'b1;
            @(negedge clk);
        end
        sub_tick = 1'b0;
    endtask

    task automatic step_second();
        pulses(PHASES);
    endtask

    task automatic t_reset();
        check_all("R1", 8'h00, 8'h00, 8'h00, 3'd1, 8'h01, 8'h01, 8'h00, 6'h20);
    endtask

    task automatic t_phase();
        do_load(8'h56, 8'h34, 8'h12, 3'd3, 8'h15, 8'h06, 8'h24, 6'h20);
        pulses(PHASES - 1);
        check_all("R2", 8'h56, 8'h34, 8'h12, 3'd3, 8'h15, 8'h06, 8'h24, 6'h20);
        pulses(1);
        check_all("R2", 8'h57, 8'h34, 8'h12, 3'd3, 8'h15, 8'h06, 8'h24, 6'h20);
        repeat (6) @(negedge clk);
        check_all("R2", 8'h57, 8'h34, 8'h12, 3'd3, 8'h15, 8'h06, 8'h24, 6'h20);
        step_second();
        cmp("R2", "sec", sec_o, 8'h58);
    endtask

    task automatic t_time_carry();
        do_load(8'h59, 8'h34, 8'h12, 3'd2, 8'h10, 8'h03, 8'h24, 6'h20);
        step_second();
        check_all("R3", 8'h00, 8'h35, 8'h12, 3'd2, 8'h10, 8'h03, 8'h24, 6'h20);
        do_load(8'h59, 8'h59, 8'h09, 3'd2, 8'h10, 8'h03, 8'h24, 6'h20);
        step_second();
        check_all("R3", 8'h00, 8'h00, 8'h10, 3'd2, 8'h10, 8'h03, 8'h24, 6'h20);
    endtask

    task automatic t_day_carry();
        do_load(8'h59, 8'h59, 8'h23, 3'd3, 8'h31, 8'h01, 8'h24, 6'h20);
        step_second();
        check_all("R3 R4 R6", 8'h00, 8'h00, 8'h00, 3'd4, 8'h01, 8'h02, 8'h24, 6'h20);
    endtask

    task automatic t_leap();
        do_load(8'h59, 8'h59, 8'h23, 3'd7, 8'h28, 8'h02, 8'h24, 6'h20);
        step_second();
        check_all("R5 R6", 8'h00, 8'h00, 8'h00, 3'd1, 8'h29, 8'h02, 8'h24, 6'h20);
        do_load(8'h59, 8'h59, 8'h23, 3'd1, 8'h29, 8'h02, 8'h24, 6'h20);
        step_second();
        check_all("R5", 8'h00, 8'h00, 8'h00, 3'd2, 8'h01, 8'h03, 8'h24, 6'h20);
        do_load(8'h59, 8'h59, 8'h23, 3'd2, 8'h28, 8'h02, 8'h23, 6'h20);
        step_second();
        check_all("R5", 8'h00, 8'h00, 8'h00, 3'd3, 8'h01, 8'h03, 8'h23, 6'h20);
        do_load(8'h59, 8'h59, 8'h23, 3'd2, 8'h28, 8'h02, 8'h12, 6'h20);
        step_second();
        cmp("R5", "date y12", date_o, 8'h29);
        do_load(8'h59, 8'h59, 8'h23, 3'd2, 8'h28, 8'h02, 8'h10, 6'h20);
        step_second();
        cmp("R5", "date y10", date_o, 8'h01);
        cmp("R5", "month y10", month_o, 8'h03);
        do_load(8'h59, 8'h59, 8'h23, 3'd2, 8'h28, 8'h02, 8'h00, 6'h20);
        step_second();
        cmp("R5", "date y00", date_o, 8'h29);
    endtask

    task automatic t_month_len();
        do_load(8'h59, 8'h59, 8'h23, 3'd5, 8'h30, 8'h04, 8'h24, 6'h20);
        step_second();
        check_all("R4", 8'h00, 8'h00, 8'h00, 3'd6, 8'h01, 8'h05, 8'h24, 6'h20);
        do_load(8'h59, 8'h59, 8'h23, 3'd5, 8'h30, 8'h09, 8'h24, 6'h20);
        step_second();
        check_all("R4", 8'h00, 8'h00, 8'h00, 3'd6, 8'h01, 8'h10, 8'h24, 6'h20);
        do_load(8'h59, 8'h59, 8'h23, 3'd5, 8'h30, 8'h08, 8'h24, 6'h20);
        step_second();
        cmp("R4", "date aug30", date_o, 8'h31);
        cmp("R4", "month aug30", month_o, 8'h08);
        do_load(8'h59, 8'h59, 8'h23, 3'd5, 8'h30, 8'h11, 8'h24, 6'h20);
        step_second();
        cmp("R4", "month nov30", month_o, 8'h12);
    endtask

    task automatic t_year_century();
        do_load(8'h59, 8'h59, 8'h23, 3'd7, 8'h31, 8'h12, 8'h23, 6'h20);
        step_second();
        check_all("R7", 8'h00, 8'h00, 8'h00, 3'd1, 8'h01, 8'h01, 8'h24, 6'h20);
        do_load(8'h59, 8'h59, 8'h23, 3'd7, 8'h31, 8'h12, 8'h99, 6'h20);
        step_second();
        check_all("R7", 8'h00, 8'h00, 8'h00, 3'd1, 8'h01, 8'h01, 8'h00, 6'h21);
        do_load(8'h59, 8'h59, 8'h23, 3'd4, 8'h31, 8'h12, 8'h99, 6'h39);
        step_second();
        check_all("R7", 8'h00, 8'h00, 8'h00, 3'd5, 8'h01, 8'h01, 8'h00, 6'h00);
    endtask

    task automatic t_over_limit();
        do_load(8'h59, 8'h59, 8'h23, 3'd1, 8'h31, 8'h04, 8'h24, 6'h20);
        step_second();
        check_all("R10", 8'h00, 8'h00, 8'h00, 3'd2, 8'h01, 8'h05, 8'h24, 6'h20);
    endtask

    task automatic t_stop();
        do_load(8'h30, 8'h20, 8'h10, 3'd4, 8'h05, 8'h07, 8'h24, 6'h20);
        stop = 1'b1;
        step_second();
        step_second();
        check_all("R9", 8'h30, 8'h20, 8'h10, 3'd4, 8'h05, 8'h07, 8'h24, 6'h20);
        do_load(8'h07, 8'h06, 8'h05, 3'd2, 8'h09, 8'h10, 8'h25, 6'h20);
        check_all("R8", 8'h07, 8'h06, 8'h05, 3'd2, 8'h09, 8'h10, 8'h25, 6'h20);
        stop = 1'b0;
        pulses(1);
        cmp("R9", "sec halt cycle", sec_o, 8'h07);
        step_second();
        cmp("R9", "sec resumed", sec_o, 8'h08);
    endtask

    task automatic t_load_phase();
        do_load(8'h10, 8'h00, 8'h00, 3'd1, 8'h01, 8'h01, 8'h24, 6'h20);
        pulses(2);
        do_load(8'h40, 8'h11, 8'h08, 3'd6, 8'h20, 8'h05, 8'h24, 6'h20);
        pulses(PHASES - 1);
        cmp("R8", "sec after restart", sec_o, 8'h40);
        pulses(1);
        check_all("R8", 8'h41, 8'h11, 8'h08, 3'd6, 8'h20, 8'h05, 8'h24, 6'h20);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_phase();
        t_time_carry();
        t_day_carry();
        t_leap();
        t_month_len();
        t_year_century();
        t_over_limit();
        t_stop();
        t_load_phase();
        finish_run();
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule